// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block is the power-mode state machine for a small microcontroller core. It records which of nine operating states the core is in. Three of them run the CPU: active at high speed, active at medium speed, and subactive on the slow subclock. Five are halt states: sleep at high speed, sleep at medium speed, subsleep, standby and watch. The ninth is reset. From this state it drives the enables for the system clock, the subclock and the CPU clock.

The CPU raises a one-cycle sleep strobe when it executes its sleep instruction. The controller then reads a five-bit configuration word to choose the destination. That destination is either a halt state or a direct transfer to another running state without a halt. Each halt state has its own group of interrupt sources that may end it. A halt ends only when the interrupt controller signals that it has accepted one of those sources. A request that is only pending does nothing. A configuration word that matches no legal combination leaves the state as it is and sets a sticky fault flag.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge the state becomes reset (code 0), all clock enables are 0 and `cfg_fault` is 0. The first edge with `rst` low moves the state to active high-speed. Any code outside 0..8 also falls back to reset.
- R2: The state codes are 0 reset, 1 active high, 2 active medium, 3 subactive, 4 sleep high, 5 sleep medium, 6 subsleep, 7 standby, 8 watch. The configuration word holds five fields: bit 4 selects low speed, bit 3 selects medium speed, bit 2 selects deep halt, bit 1 keeps the timebase, and bit 0 selects a direct transfer.
- R3: When a sleep strobe arrives in a running state with bit 0 = 0: bits 4 and 2 both 0 give sleep high (bit 3 = 0) or sleep medium (bit 3 = 1), whatever bit 1 holds. Bit 4 = 1 with bit 2 = 0 and bit 1 = 1 gives subsleep, whatever bit 3 holds.
- R4: When a sleep strobe arrives with bit 0 = 0 and bit 2 = 1: bit 1 = 1 gives watch whatever bits 4 and 3 hold, and bit 4 = 0 with bit 1 = 0 gives standby.
- R5: When a sleep strobe arrives with bit 0 = 1, the transfer is direct. Bits 4 and 2 both 0 give active high (bit 3 = 0) or active medium (bit 3 = 1). Bit 4 = 1 with bits 2 and 1 = 1 gives subactive. Bit 4 = 0 with bits 2 and 1 = 1 gives active high or active medium, chosen by bit 3.
- R6: A sleep strobe with any other combination leaves the state unchanged and sets `cfg_fault`. Only reset clears the flag.
- R7: A sleep strobe has no effect in a halt state or in reset.
- R8: The two sleep states end on any accepted source and return to the running state that was current when the halt began.
- R9: Standby ends only on accepted sources 3, 4 and 7..14 (external lines 0 and 1, wake pins 0..7).
- R10: Watch ends only on accepted sources 0, 1, 3 and 7..14 (timer A, timer F, external line 0, wake pins).
- R11: Subsleep ends only on accepted sources 0..14 (the watch group plus serial 2, external line 1, and event-counter sources 5 and 6). Source 15 does not end it.
- R12: When standby, watch or subsleep ends, the next state depends on the current configuration word: subactive if bit 4 = 1, otherwise active medium if bit 3 = 1, otherwise active high.
- R13: With `intr_ack` low the halt state holds, whatever `intr_src` carries.
- R14: Clock enables by state. System clock: 1, 2, 4, 5. Subclock: 3, 6, 8. CPU clock: 1, 2, 3. `cpu_mid_spd`: state 2 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | One-cycle sleep-instruction strobe |
| pm_cfg | input | 5 | Mode configuration word (fields in R2) |
| intr_ack | input | 1 | Interrupt accepted strobe |
| intr_src | input | 4 | Identifier of the accepted interrupt source |
| mode_code | output | 4 | Current state code |
| sys_clk_en | output | 1 | System oscillator clock enable |
| sub_clk_en | output | 1 | Subclock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| cpu_mid_spd | output | 1 | CPU runs at medium speed |
| cfg_fault | output | 1 | Sticky illegal-configuration flag |

## Verification
The bench walks the configuration words around every don't-care position. A decoder that treats an ignored bit as significant sends those words into the fault path, or the reverse. Each of the three restricted halts is offered a source just outside its group, for example timer A in standby or external line 1 in watch. A design with a crossed group mask would then wake when it should hold. Sleep is entered from subactive and from active medium. A controller that always resumes at high speed would come back to the wrong running state. The bench also sends a valid strobe after a fault, which catches a flag that is not sticky, and sends sleep strobes in halt states, which catches a design that leaves a halt without an accepted interrupt.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int CFG_W        = 5;
    localparam int MODE_W       = 4;
    localparam int WAKE_PIN_CNT = 8;
    localparam int SRC_CNT      = 16;
    localparam int SRC_W        = $clog2(SRC_CNT);

    // interrupt source identifiers
    localparam int SRC_TMR_A   = 0;
    localparam int SRC_TMR_F   = 1;
    localparam int SRC_SERIAL  = 2;
    localparam int SRC_EXT0    = 3;
    localparam int SRC_EXT1    = 4;
    localparam int SRC_EVC     = 5;
    localparam int SRC_EVC_EXT = 6;
    localparam int SRC_PIN0    = 7;
    localparam int SRC_PIN_END = SRC_PIN0 + WAKE_PIN_CNT;

    typedef enum logic [MODE_W-1:0] {
        ST_RESET   = 4'd0,
        ST_ACT_HI  = 4'd1,
        ST_ACT_MED = 4'd2,
        ST_SUBACT  = 4'd3,
        ST_SLP_HI  = 4'd4,
        ST_SLP_MED = 4'd5,
        ST_SUBSLP  = 4'd6,
        ST_STBY    = 4'd7,
        ST_WATCH   = 4'd8
    } pm_state_e;

    typedef struct packed {
        logic low_spd;   // bit 4
        logic mid_spd;   // bit 3
        logic deep;      // bit 2
        logic tb_keep;   // bit 1
        logic direct;    // bit 0
    } pm_cfg_t;

    typedef struct packed {
        logic sys_en;
        logic sub_en;
        logic cpu_en;
        logic cpu_mid;
    } clk_ctl_t;

    typedef enum logic [1:0] {
        GRP_ANY,
        GRP_STBY,
        GRP_WATCH,
        GRP_SUBSLP
    } wake_grp_e;

    function automatic logic [SRC_CNT-1:0] pin_mask();
        logic [SRC_CNT-1:0] m;
        m = '0;
        for (int i = SRC_PIN0; i < SRC_PIN_END; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [SRC_CNT-1:0] group_mask(wake_grp_e g);
        logic [SRC_CNT-1:0] m;
        m = pin_mask();
        case (g)
            GRP_STBY: begin
                m[SRC_EXT0] = 1'b1;
                m[SRC_EXT1] = 1'b1;
            end
            GRP_WATCH: begin
                m[SRC_TMR_A] = 1'b1;
                m[SRC_TMR_F] = 1'b1;
                m[SRC_EXT0]  = 1'b1;
            end
            GRP_SUBSLP: begin
                m[SRC_TMR_A]   = 1'b1;
                m[SRC_TMR_F]   = 1'b1;
                m[SRC_SERIAL]  = 1'b1;
                m[SRC_EXT0]    = 1'b1;
                m[SRC_EXT1]    = 1'b1;
                m[SRC_EVC]     = 1'b1;
                m[SRC_EVC_EXT] = 1'b1;
            end
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic logic is_halt(pm_state_e s);
        return (s == ST_SLP_HI) || (s == ST_SLP_MED) || (s == ST_SUBSLP) ||
               (s == ST_STBY) || (s == ST_WATCH);
    endfunction

    function automatic logic is_run(pm_state_e s);
        return (s == ST_ACT_HI) || (s == ST_ACT_MED) || (s == ST_SUBACT);
    endfunction

endpackage

// File: rtl/lpm_sleep_decode.sv
module lpm_sleep_decode
    import lpm_pkg::*;
(
    input  pm_cfg_t   cfg,
    output pm_state_e target,
    output logic      legal
);

    pm_state_e halt_tgt;
    pm_state_e xfer_tgt;
    logic      halt_ok;
    logic      xfer_ok;

    // halt destinations (direct = 0)
    always_comb begin
        halt_tgt = ST_SLP_HI;
        halt_ok  = 1'b1;
        if (!cfg.deep && !cfg.low_spd) begin
            halt_tgt = cfg.mid_spd ? ST_SLP_MED : ST_SLP_HI;
        end else if (!cfg.deep && cfg.low_spd && cfg.tb_keep) begin
            halt_tgt = ST_SUBSLP;
        end else if (cfg.deep && cfg.tb_keep) begin
            halt_tgt = ST_WATCH;
        end else if (cfg.deep && !cfg.low_spd && !cfg.tb_keep) begin
            halt_tgt = ST_STBY;
        end else begin
            halt_ok = 1'b0;
        end
    end

    // direct transfers between running states (direct = 1)
    always_comb begin
        xfer_tgt = ST_ACT_HI;
        xfer_ok  = 1'b1;
        if (!cfg.low_spd && !cfg.deep) begin
            xfer_tgt = cfg.mid_spd ? ST_ACT_MED : ST_ACT_HI;
        end else if (cfg.deep && cfg.tb_keep && cfg.low_spd) begin
            xfer_tgt = ST_SUBACT;
        end else if (cfg.deep && cfg.tb_keep && !cfg.low_spd) begin
            xfer_tgt = cfg.mid_spd ? ST_ACT_MED : ST_ACT_HI;
        end else begin
            xfer_ok = 1'b0;
        end
    end

    assign target = cfg.direct ? xfer_tgt : halt_tgt;
    assign legal  = cfg.direct ? xfer_ok  : halt_ok;

    always_comb begin
        if (legal && cfg.direct) assert_xfer_runs_R5: assert (is_run(target));
        if (legal && !cfg.direct) assert_halt_dest_R3: assert (is_halt(target));
    end

endmodule

// File: rtl/lpm_wake_gate.sv
module lpm_wake_gate
    import lpm_pkg::*;
(
    input  pm_state_e        cur,
    input  logic             ack,
    input  logic [SRC_W-1:0] src,
    output logic             wake
);

    wake_grp_e          grp;
    logic [SRC_CNT-1:0] allow;
    logic [SRC_CNT-1:0] hit;

    always_comb begin
        case (cur)
            ST_STBY:   grp = GRP_STBY;
            ST_WATCH:  grp = GRP_WATCH;
            ST_SUBSLP: grp = GRP_SUBSLP;
            default:   grp = GRP_ANY;
        endcase
    end

    assign allow = group_mask(grp);

    for (genvar g = 0; g < SRC_CNT; g++) begin : g_src
        assign hit[g] = allow[g] && (src == SRC_W'(g));
    end

    assign wake = ack && is_halt(cur) && (|hit);

    always_comb begin
        if (wake) assert_wake_needs_ack_R13: assert (ack && $onehot(hit));
    end

endmodule

// File: rtl/lpm_clk_decode.sv
module lpm_clk_decode
    import lpm_pkg::*;
(
    input  pm_state_e cur,
    output clk_ctl_t  ctl
);

    always_comb begin
        ctl = '0;
        case (cur)
            ST_ACT_HI:  begin ctl.sys_en = 1'b1; ctl.cpu_en = 1'b1; end
            ST_ACT_MED: begin ctl.sys_en = 1'b1; ctl.cpu_en = 1'b1; ctl.cpu_mid = 1'b1; end
            ST_SUBACT:  begin ctl.sub_en = 1'b1; ctl.cpu_en = 1'b1; end
            ST_SLP_HI,
            ST_SLP_MED: ctl.sys_en = 1'b1;
            ST_SUBSLP,
            ST_WATCH:   ctl.sub_en = 1'b1;
            default:    ctl = '0;
        endcase
    end

    always_comb begin
        assert_one_source_R14: assert (!(ctl.sys_en && ctl.sub_en));
        if (ctl.cpu_en) assert_cpu_has_clock_R14: assert (ctl.sys_en || ctl.sub_en);
    end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic [CFG_W-1:0] pm_cfg,
    input  logic             intr_ack,
    input  logic [SRC_W-1:0] intr_src,
    output logic [MODE_W-1:0] mode_code,
    output logic             sys_clk_en,
    output logic             sub_clk_en,
    output logic             cpu_clk_en,
    output logic             cpu_mid_spd,
    output logic             cfg_fault
);

    pm_cfg_t   cfg;
    pm_state_e cur, nxt;
    pm_state_e prev_run, nxt_prev;
    pm_state_e dec_tgt;
    pm_state_e resume_tgt;
    logic      dec_legal;
    logic      wake;
    logic      fault_q, fault_set;
    clk_ctl_t  ctl;

    assign cfg = pm_cfg_t'(pm_cfg);

    lpm_sleep_decode u_dec (
        .cfg    (cfg),
        .target (dec_tgt),
        .legal  (dec_legal)
    );

    lpm_wake_gate u_wake (
        .cur  (cur),
        .ack  (intr_ack),
        .src  (intr_src),
        .wake (wake)
    );

    lpm_clk_decode u_clk (
        .cur (cur),
        .ctl (ctl)
    );

    always_comb begin
        if (cfg.low_spd)      resume_tgt = ST_SUBACT;
        else if (cfg.mid_spd) resume_tgt = ST_ACT_MED;
        else                  resume_tgt = ST_ACT_HI;
    end

    always_comb begin
        nxt       = cur;
        nxt_prev  = prev_run;
        fault_set = 1'b0;
        case (cur)
            ST_RESET: nxt = ST_ACT_HI;
            ST_ACT_HI, ST_ACT_MED, ST_SUBACT: begin
                if (sleep_req) begin
                    if (dec_legal) begin
                        nxt = dec_tgt;
                        if (is_halt(dec_tgt)) nxt_prev = cur;
                    end else begin
                        fault_set = 1'b1;
                    end
                end
            end
            ST_SLP_HI, ST_SLP_MED: if (wake) nxt = prev_run;
            ST_SUBSLP, ST_STBY, ST_WATCH: if (wake) nxt = resume_tgt;
            default: nxt = ST_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= ST_RESET;
            prev_run <= ST_ACT_HI;
            fault_q  <= 1'b0;
        end else begin
            cur      <= nxt;
            prev_run <= nxt_prev;
            fault_q  <= fault_q | fault_set;
        end
    end

    assign mode_code   = cur;
    assign sys_clk_en  = ctl.sys_en;
    assign sub_clk_en  = ctl.sub_en;
    assign cpu_clk_en  = ctl.cpu_en;
    assign cpu_mid_spd = ctl.cpu_mid;
    assign cfg_fault   = fault_q;

    assert_reset_exit_R1: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_RESET) |=> (cur == ST_ACT_HI));

    assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
        (cur <= ST_WATCH));

    assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        fault_q |=> fault_q);

    assert_fault_holds_state_R6: assert property (@(posedge clk) disable iff (rst)
        (is_run(cur) && sleep_req && !dec_legal) |=> ($stable(cur) && fault_q));

    assert_halt_ignores_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (is_halt(cur) && sleep_req && !intr_ack) |=> $stable(cur));

    assert_sleep_resume_R8: assert property (@(posedge clk) disable iff (rst)
        ((cur == ST_SLP_HI || cur == ST_SLP_MED) && intr_ack) |=> (cur == $past(prev_run)));

    assert_stby_rejects_timer_R9: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_STBY && intr_ack && intr_src == SRC_W'(SRC_TMR_A)) |=> (cur == ST_STBY));

    assert_watch_rejects_ext1_R10: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_WATCH && intr_ack && intr_src == SRC_W'(SRC_EXT1)) |=> (cur == ST_WATCH));

    assert_subslp_to_subact_R12: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_SUBSLP && wake && cfg.low_spd) |=> (cur == ST_SUBACT));

    assert_hold_without_ack_R13: assert property (@(posedge clk) disable iff (rst)
        (is_halt(cur) && !intr_ack) |=> $stable(cur));

endmodule

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_req = 1'b0;
    logic [4:0] pm_cfg = 5'd0;
    logic       intr_ack = 1'b0;
    logic [3:0] intr_src = 4'd0;
    logic [3:0] mode_code;
    logic       sys_clk_en, sub_clk_en, cpu_clk_en, cpu_mid_spd, cfg_fault;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lpm_ctrl u0 (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .pm_cfg(pm_cfg),
        .intr_ack(intr_ack), .intr_src(intr_src), .mode_code(mode_code),
        .sys_clk_en(sys_clk_en), .sub_clk_en(sub_clk_en), .cpu_clk_en(cpu_clk_en),
        .cpu_mid_spd(cpu_mid_spd), .cfg_fault(cfg_fault)
    );

    // {cfg[4:0], expected code, expected fault}, strobe issued from active high
    localparam logic [9:0] VEC [22] = '{
        {5'b00000, 4'd4, 1'b0}, {5'b00010, 4'd4, 1'b0},
        {5'b01000, 4'd5, 1'b0}, {5'b01010, 4'd5, 1'b0},
        {5'b10010, 4'd6, 1'b0}, {5'b11010, 4'd6, 1'b0},
        {5'b00100, 4'd7, 1'b0}, {5'b01100, 4'd7, 1'b0},
        {5'b00110, 4'd8, 1'b0}, {5'b11110, 4'd8, 1'b0},
        {5'b10000, 4'd1, 1'b1}, {5'b10100, 4'd1, 1'b1},
        {5'b00001, 4'd1, 1'b0}, {5'b01001, 4'd2, 1'b0},
        {5'b01011, 4'd2, 1'b0}, {5'b10111, 4'd3, 1'b0},
        {5'b11111, 4'd3, 1'b0}, {5'b00111, 4'd1, 1'b0},
        {5'b01111, 4'd2, 1'b0}, {5'b00101, 4'd1, 1'b1},
        {5'b10001, 4'd1, 1'b1}, {5'b11001, 4'd1, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_clk(input string tag, input int code);
        int e_sys, e_sub, e_cpu, e_mid;
        e_sys = (code == 1 || code == 2 || code == 4 || code == 5) ? 1 : 0;
        e_sub = (code == 3 || code == 6 || code == 8) ? 1 : 0;
        e_cpu = (code >= 1 && code <= 3) ? 1 : 0;
        e_mid = (code == 2) ? 1 : 0;
        chk(tag, {sys_clk_en, sub_clk_en, cpu_clk_en, cpu_mid_spd},
            {e_sys[0], e_sub[0], e_cpu[0], e_mid[0]});
    endtask

    task automatic do_reset();
        rst = 1'b1; sleep_req = 1'b0; intr_ack = 1'b0;
        tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic strobe(input logic [4:0] c);
        pm_cfg = c; sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
    endtask

    task automatic accept(input int s);
        intr_src = s[3:0]; intr_ack = 1'b1;
        tick();
        intr_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        // R1 reset state
        tick();
        chk("R1 code in reset", mode_code, 0);
        chk("R1 fault in reset", cfg_fault, 0);
        chk_clk("R1 R14 enables in reset", 0);
        rst = 1'b0;
        tick();
        chk("R1 leave reset", mode_code, 1);
        chk_clk("R14 active high enables", 1);

        // R2 R3 R4 R5 R6 decode table
        for (int i = 0; i < 22; i++) begin
            do_reset();
            strobe(VEC[i][9:5]);
            chk($sformatf("R3 R4 R5 row %0d code", i), mode_code, int'(VEC[i][4:1]));
            chk($sformatf("R6 row %0d fault", i), cfg_fault, int'(VEC[i][0]));
            chk_clk($sformatf("R14 row %0d enables", i), int'(VEC[i][4:1]));
        end

        // R6 sticky fault, cleared only by reset
        do_reset();
        strobe(5'b10000);
        strobe(5'b01001);
        chk("R6 valid strobe after fault moves", mode_code, 2);
        chk("R6 fault sticky", cfg_fault, 1);
        do_reset();
        chk("R6 reset clears fault", cfg_fault, 0);

        // R8 sleep returns to medium speed
        strobe(5'b01001);
        strobe(5'b01000);
        chk("R8 sleep med entered", mode_code, 5);
        accept(15);
        chk("R8 resume active medium", mode_code, 2);
        chk_clk("R14 medium enables", 2);

        // R8 sleep from subactive returns to subactive
        strobe(5'b10111);
        chk("R5 subactive", mode_code, 3);
        strobe(5'b00000);
        chk("R8 sleep high from subactive", mode_code, 4);
        accept(2);
        chk("R8 resume subactive", mode_code, 3);

        // R9 standby group, R7 strobe ignored, R13 no ack
        do_reset();
        strobe(5'b00100);
        strobe(5'b00001);
        chk("R7 strobe ignored in standby", mode_code, 7);
        accept(0);
        chk("R9 timer A rejected in standby", mode_code, 7);
        accept(2);
        chk("R9 serial rejected in standby", mode_code, 7);
        intr_src = 4'd4;
        tick(); tick();
        chk("R13 pending without ack holds", mode_code, 7);
        pm_cfg = 5'b01100;
        accept(4);
        chk("R9 R12 ext1 wakes standby to medium", mode_code, 2);

        // R10 watch group
        do_reset();
        strobe(5'b00110);
        accept(4);
        chk("R10 ext1 rejected in watch", mode_code, 8);
        accept(2);
        chk("R10 serial rejected in watch", mode_code, 8);
        pm_cfg = 5'b10110;
        accept(1);
        chk("R10 R12 timer F wakes watch to subactive", mode_code, 3);
        strobe(5'b11110);
        pm_cfg = 5'b00110;
        accept(14);
        chk("R10 R12 pin 7 wakes watch to active high", mode_code, 1);

        // R11 subsleep group
        strobe(5'b10010);
        chk("R3 subsleep entered", mode_code, 6);
        chk_clk("R14 subsleep enables", 6);
        accept(15);
        chk("R11 source 15 rejected in subsleep", mode_code, 6);
        accept(5);
        chk("R11 R12 event counter wakes subsleep", mode_code, 3);

        // R7 strobe in reset ignored
        rst = 1'b1; pm_cfg = 5'b00100; sleep_req = 1'b1;
        tick();
        chk("R7 strobe during reset", mode_code, 0);
        rst = 1'b0;
        tick();
        sleep_req = 1'b0;
        chk("R7 R1 reset exit ignores strobe", mode_code, 1);

        finish_run();
    end

endmodule